// File: doc/BRIEF.md
# MMU Fault Status Capture

This block sits after the translation-buffer lookup of a memory management unit. For every access it receives the access kind (data load, data store or instruction fetch), the selected context, the processor mode, the trap level, the lookup hit flag and the permission bits of the matching entry. From these it classifies the access as allowed, a privilege fault, a protection fault or a miss, and reports that class on the same cycle.

On a permission fault it writes a fault status record and, on the data side, the faulting virtual address. On a miss it loads only a tag-access register, and the status and address registers keep their values. Data and instruction sides keep separate status and tag-access registers. Each side has a read strobe that retires the valid and overflow bits of its status record. If a second fault arrives before the first record was retired, the new record is flagged as an overflow.

Top module: `mmu_fault_capture`

## Requirements
- R1: On an access with hit_i low, fault_kind_o is 3 (miss). The status registers and dfar_o stay unchanged. The tag-access register of the accessing side is loaded with {vaddr_i[VA_W-1:13], effective context}.
- R2: A hit by a user-mode access on an entry with pte_priv_i set gives fault_kind_o 1 (privilege fault), and status bit 7 is set. This holds for fetches too, and it wins over the write check on data stores.
- R3: A data store that hits an entry with pte_write_i low, and is not a privilege fault, gives fault_kind_o 2 (protection fault). Status bit 2 is set and bits 13:7 are zero.
- R4: An instruction fetch never gives a protection fault, whatever acc_store_i and pte_write_i are. Such a fetch reports 0 (no fault) unless R2 applies.
- R5: A fault writes a fresh status record: bit 0 valid is 1, bit 2 is 1 for data stores, bit 3 copies priv_state_i, bits 5:4 hold the context type (0 primary, 1 secondary, 2 nucleus), bit 7 marks a privilege fault, and every other bit is 0.
- R6: If the side's status valid bit is already set when a new fault is captured, the new record has bit 1 (overflow) set.
- R7: A data fault loads dfar_o with vaddr_i. Any fault also loads the side's tag-access register as in R1.
- R8: On the data side, ctx_sel_i 0, 1 and 2 (and 3) give context types primary, secondary and nucleus. On the fetch side the context type is nucleus when trap_level_i is nonzero and primary otherwise. A nucleus context puts 0 in tag bits 12:0.
- R9: A status read strobe with no fault on that side clears bits 1:0 of that status register on the next cycle and keeps the other bits.
- R10: If a read strobe and a fault hit the same side in the same cycle, the fault's record is written with overflow clear.
- R11: After reset all registers are zero. With acc_valid_i low, fault_kind_o is 0 and no register changes.
- R12: A fault or miss on one side leaves the other side's status and tag-access registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| acc_valid_i | input | 1 | A looked-up access is presented |
| acc_fetch_i | input | 1 | 1 for instruction fetch, 0 for data |
| acc_store_i | input | 1 | Data access is a store |
| ctx_sel_i | input | 2 | Data context: 0 primary, 1 secondary, 2/3 nucleus |
| user_mode_i | input | 1 | Access is made in user mode |
| priv_state_i | input | 1 | Processor is in privileged state |
| trap_level_i | input | TL_W | Current trap level |
| hit_i | input | 1 | Lookup found a matching entry |
| pte_priv_i | input | 1 | Matching entry is privileged-only |
| pte_write_i | input | 1 | Matching entry allows writes |
| vaddr_i | input | VA_W | Virtual address of the access |
| ctx_id_i | input | CTX_W | Context number of the selected context |
| dstat_rd_i | input | 1 | Data status read strobe |
| istat_rd_i | input | 1 | Instruction status read strobe |
| fault_kind_o | output | 2 | 0 none, 1 privilege, 2 protection, 3 miss |
| dstat_o | output | 14 | Data fault status register |
| dfar_o | output | VA_W | Data fault address register |
| dtag_o | output | VA_W | Data tag-access register |
| istat_o | output | 14 | Instruction fault status register |
| itag_o | output | VA_W | Instruction tag-access register |

## Verification
A status read strobe and a new fault can land on the same side in the same cycle. The read then competes with the record rewrite, and the overflow bit depends on which one wins. The bench first leaves a valid record in place. It then raises the data read strobe in the very cycle of a second data fault, and it expects the fresh record with valid set and overflow clear. Back-to-back faults with no strobe must give overflow set, and a strobe alone must clear only bits 1:0.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
  typedef enum logic [1:0] {
    FK_NONE = 2'd0,
    FK_PRIV = 2'd1,
    FK_PROT = 2'd2,
    FK_MISS = 2'd3
  } fault_kind_e;

  typedef enum logic [1:0] {
    CT_PRIMARY   = 2'd0,
    CT_SECONDARY = 2'd1,
    CT_NUCLEUS   = 2'd2
  } ctx_type_e;

  localparam int unsigned STAT_W   = 14;
  localparam int unsigned ST_VALID = 0;
  localparam int unsigned ST_OVF   = 1;
  localparam int unsigned ST_WRITE = 2;
  localparam int unsigned ST_PRIV  = 3;
  localparam int unsigned ST_CT_LO = 4;
  localparam int unsigned ST_FT_LO = 7;

  localparam int unsigned SIDE_DATA  = 0;
  localparam int unsigned SIDE_FETCH = 1;
  localparam int unsigned N_SIDES    = 2;
endpackage

// File: rtl/mfc_perm_check.sv
module mfc_perm_check
  import mfc_pkg::*;
(
  input  logic        acc_valid_i,
  input  logic        is_fetch_i,
  input  logic        is_store_i,
  input  logic        user_i,
  input  logic        hit_i,
  input  logic        pte_priv_i,
  input  logic        pte_write_i,
  output fault_kind_e kind_o
);
  // privilege check first; write check is data-only
  always_comb begin
    kind_o = FK_NONE;
    if (acc_valid_i) begin
      if (!hit_i)                                   kind_o = FK_MISS;
      else if (pte_priv_i && user_i)                kind_o = FK_PRIV;
      else if (!is_fetch_i && is_store_i && !pte_write_i) kind_o = FK_PROT;
    end
  end
endmodule

// File: rtl/mfc_ctx_select.sv
module mfc_ctx_select
  import mfc_pkg::*;
#(
  parameter int unsigned CTX_W = 13,
  parameter int unsigned TL_W  = 3
) (
  input  logic             is_fetch_i,
  input  logic [1:0]       ctx_sel_i,
  input  logic [TL_W-1:0]  trap_level_i,
  input  logic [CTX_W-1:0] ctx_id_i,
  output logic [1:0]       ctx_type_o,
  output logic [CTX_W-1:0] ctx_eff_o
);
  ctx_type_e ct;

  always_comb begin
    if (is_fetch_i) begin
      ct = (trap_level_i != '0) ? CT_NUCLEUS : CT_PRIMARY;
    end else begin
      unique case (ctx_sel_i)
        2'd0:    ct = CT_PRIMARY;
        2'd1:    ct = CT_SECONDARY;
        default: ct = CT_NUCLEUS;
      endcase
    end
  end

  assign ctx_type_o = ct;
  assign ctx_eff_o  = (ct == CT_NUCLEUS) ? '0 : ctx_id_i;
endmodule

// File: rtl/mfc_status_reg.sv
module mfc_status_reg
  import mfc_pkg::*;
#(
  parameter bit FETCH_SIDE = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic              rd_i,
  input  logic              store_i,
  input  logic              priv_state_i,
  input  logic              priv_fault_i,
  input  logic [1:0]        ctx_type_i,
  output logic [STAT_W-1:0] stat_o
);
  logic [STAT_W-1:0] stat_q, stat_d, rec;

  always_comb begin
    rec                  = '0;
    rec[ST_VALID]        = 1'b1;
    // a read in the same cycle retires the old record
    rec[ST_OVF]          = stat_q[ST_VALID] & ~rd_i;
    rec[ST_WRITE]        = FETCH_SIDE ? 1'b0 : store_i;
    rec[ST_PRIV]         = priv_state_i;
    rec[ST_CT_LO +: 2]   = ctx_type_i;
    rec[ST_FT_LO]        = priv_fault_i;

    stat_d = stat_q;
    if (capture_i) begin
      stat_d = rec;
    end else if (rd_i) begin
      stat_d[ST_VALID] = 1'b0;
      stat_d[ST_OVF]   = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/mfc_va_reg.sv
module mfc_va_reg #(
  parameter int unsigned W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/mmu_fault_capture.sv
module mmu_fault_capture
  import mfc_pkg::*;
#(
  parameter int unsigned VA_W  = 64,
  parameter int unsigned CTX_W = 13,
  parameter int unsigned TL_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic              acc_fetch_i,
  input  logic              acc_store_i,
  input  logic [1:0]        ctx_sel_i,
  input  logic              user_mode_i,
  input  logic              priv_state_i,
  input  logic [TL_W-1:0]   trap_level_i,
  input  logic              hit_i,
  input  logic              pte_priv_i,
  input  logic              pte_write_i,
  input  logic [VA_W-1:0]   vaddr_i,
  input  logic [CTX_W-1:0]  ctx_id_i,
  input  logic              dstat_rd_i,
  input  logic              istat_rd_i,
  output logic [1:0]        fault_kind_o,
  output logic [STAT_W-1:0] dstat_o,
  output logic [VA_W-1:0]   dfar_o,
  output logic [VA_W-1:0]   dtag_o,
  output logic [STAT_W-1:0] istat_o,
  output logic [VA_W-1:0]   itag_o
);
  fault_kind_e      kind;
  logic [1:0]       ctx_type;
  logic [CTX_W-1:0] ctx_eff;
  logic             is_fault, is_miss;
  logic [VA_W-1:0]  tag_val;
  logic [STAT_W-1:0] stat_w [N_SIDES];
  logic [VA_W-1:0]   tag_w  [N_SIDES];

  mfc_perm_check u_perm (
    .acc_valid_i (acc_valid_i),
    .is_fetch_i  (acc_fetch_i),
    .is_store_i  (acc_store_i),
    .user_i      (user_mode_i),
    .hit_i       (hit_i),
    .pte_priv_i  (pte_priv_i),
    .pte_write_i (pte_write_i),
    .kind_o      (kind)
  );

  mfc_ctx_select #(.CTX_W(CTX_W), .TL_W(TL_W)) u_ctx (
    .is_fetch_i   (acc_fetch_i),
    .ctx_sel_i    (ctx_sel_i),
    .trap_level_i (trap_level_i),
    .ctx_id_i     (ctx_id_i),
    .ctx_type_o   (ctx_type),
    .ctx_eff_o    (ctx_eff)
  );

  assign is_fault = (kind == FK_PRIV) || (kind == FK_PROT);
  assign is_miss  = (kind == FK_MISS);
  assign tag_val  = {vaddr_i[VA_W-1:CTX_W], ctx_eff};

  for (genvar s = 0; s < N_SIDES; s++) begin : g_side
    logic on_side;
    assign on_side = (s == SIDE_FETCH) ? acc_fetch_i : ~acc_fetch_i;

    mfc_status_reg #(.FETCH_SIDE(s == SIDE_FETCH)) u_stat (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .capture_i    (on_side & is_fault),
      .rd_i         ((s == SIDE_FETCH) ? istat_rd_i : dstat_rd_i),
      .store_i      (acc_store_i),
      .priv_state_i (priv_state_i),
      .priv_fault_i (kind == FK_PRIV),
      .ctx_type_i   (ctx_type),
      .stat_o       (stat_w[s])
    );

    mfc_va_reg #(.W(VA_W)) u_tag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (on_side & (is_fault | is_miss)),
      .d_i    (tag_val),
      .q_o    (tag_w[s])
    );
  end

  mfc_va_reg #(.W(VA_W)) u_far (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (~acc_fetch_i & is_fault),
    .d_i    (vaddr_i),
    .q_o    (dfar_o)
  );

  assign fault_kind_o = kind;
  assign dstat_o      = stat_w[SIDE_DATA];
  assign istat_o      = stat_w[SIDE_FETCH];
  assign dtag_o       = tag_w[SIDE_DATA];
  assign itag_o       = tag_w[SIDE_FETCH];
endmodule

// File: rtl/mfc_checker.sv
module mfc_checker
  import mfc_pkg::*;
#(
  parameter int unsigned VA_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              acc_valid_i,
  input logic              acc_fetch_i,
  input logic              user_mode_i,
  input logic              hit_i,
  input logic              pte_priv_i,
  input logic              dstat_rd_i,
  input logic              istat_rd_i,
  input logic [VA_W-1:0]   vaddr_i,
  input logic [1:0]        fault_kind_o,
  input logic [STAT_W-1:0] dstat_o,
  input logic [STAT_W-1:0] istat_o,
  input logic [VA_W-1:0]   dfar_o
);
  logic data_fault;
  assign data_fault = acc_valid_i && !acc_fetch_i &&
                      (fault_kind_o == FK_PRIV || fault_kind_o == FK_PROT);

  a_r1_miss_keeps_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && !hit_i && !dstat_rd_i && !istat_rd_i |=>
      $stable(dstat_o) && $stable(istat_o) && $stable(dfar_o));

  a_r2_priv_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && hit_i && pte_priv_i && user_mode_i |-> fault_kind_o == FK_PRIV);

  a_r4_fetch_no_prot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_fetch_i |-> fault_kind_o != FK_PROT);

  a_r5_valid_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_fault |=> dstat_o[ST_VALID]);

  a_r6_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_fault && dstat_o[ST_VALID] && !dstat_rd_i |=> dstat_o[ST_OVF]);

  a_r7_far_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_fault |=> dfar_o == $past(vaddr_i));

  a_r9_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dstat_rd_i && !data_fault |=> !dstat_o[ST_VALID] && !dstat_o[ST_OVF]);

  a_r10_read_and_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dstat_rd_i && data_fault |=> dstat_o[ST_VALID] && !dstat_o[ST_OVF]);
endmodule

bind mmu_fault_capture mfc_checker #(.VA_W(VA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .acc_valid_i  (acc_valid_i),
  .acc_fetch_i  (acc_fetch_i),
  .user_mode_i  (user_mode_i),
  .hit_i        (hit_i),
  .pte_priv_i   (pte_priv_i),
  .dstat_rd_i   (dstat_rd_i),
  .istat_rd_i   (istat_rd_i),
  .vaddr_i      (vaddr_i),
  .fault_kind_o (fault_kind_o),
  .dstat_o      (dstat_o),
  .istat_o      (istat_o),
  .dfar_o       (dfar_o)
);

// File: tb/mmu_fault_capture_bench.sv
`timescale 1ns/1ps
module mmu_fault_capture_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_fetch = 1'b0, acc_store = 1'b0;
  logic [1:0]  ctx_sel = '0;
  logic        user_mode = 1'b0, priv_state = 1'b0;
  logic [2:0]  trap_level = '0;
  logic        hit = 1'b0, pte_priv = 1'b0, pte_write = 1'b0;
  logic [63:0] vaddr = '0;
  logic [12:0] ctx_id = '0;
  logic        dstat_rd = 1'b0, istat_rd = 1'b0;
  logic [1:0]  fault_kind;
  logic [13:0] dstat, istat;
  logic [63:0] dfar, dtag, itag;

  int n_cmp = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  mmu_fault_capture u_mmu_fault_capture (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(acc_valid), .acc_fetch_i(acc_fetch),
    .acc_store_i(acc_store), .ctx_sel_i(ctx_sel), .user_mode_i(user_mode),
    .priv_state_i(priv_state), .trap_level_i(trap_level), .hit_i(hit),
    .pte_priv_i(pte_priv), .pte_write_i(pte_write), .vaddr_i(vaddr),
    .ctx_id_i(ctx_id), .dstat_rd_i(dstat_rd), .istat_rd_i(istat_rd),
    .fault_kind_o(fault_kind), .dstat_o(dstat), .dfar_o(dfar), .dtag_o(dtag),
    .istat_o(istat), .itag_o(itag)
  );

  // {fetch, store, sel[1:0], user, priv, tl[2:0], hit, pte_priv, pte_write, kind[1:0], stat[7:0]}
  localparam int NV = 12;
  localparam logic [21:0] VEC [NV] = '{
    {1'b0,1'b0,2'd0,1'b1,1'b0,3'd0,1'b1,1'b0,1'b1,2'd0,8'h00},
    {1'b0,1'b1,2'd1,1'b1,1'b0,3'd0,1'b1,1'b0,1'b0,2'd2,8'h15},
    {1'b0,1'b0,2'd0,1'b1,1'b0,3'd0,1'b1,1'b1,1'b1,2'd1,8'h81},
    {1'b0,1'b1,2'd2,1'b1,1'b1,3'd0,1'b1,1'b1,1'b0,2'd1,8'hAD},
    {1'b0,1'b1,2'd1,1'b0,1'b1,3'd0,1'b1,1'b1,1'b0,2'd2,8'h1D},
    {1'b0,1'b1,2'd0,1'b1,1'b0,3'd0,1'b1,1'b0,1'b1,2'd0,8'h00},
    {1'b0,1'b0,2'd0,1'b1,1'b0,3'd0,1'b0,1'b0,1'b1,2'd3,8'h00},
    {1'b1,1'b0,2'd0,1'b1,1'b0,3'd0,1'b1,1'b1,1'b1,2'd1,8'h81},
    {1'b1,1'b1,2'd0,1'b1,1'b0,3'd0,1'b1,1'b0,1'b0,2'd0,8'h00},
    {1'b1,1'b0,2'd0,1'b1,1'b1,3'd2,1'b1,1'b1,1'b1,2'd1,8'hA9},
    {1'b1,1'b0,2'd0,1'b1,1'b0,3'd0,1'b0,1'b0,1'b1,2'd3,8'h00},
    {1'b0,1'b1,2'd3,1'b1,1'b0,3'd0,1'b1,1'b0,1'b0,2'd2,8'h25}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic f, input logic s, input logic [1:0] sel,
                       input logic u, input logic p, input logic [2:0] tl,
                       input logic h, input logic pp, input logic pw,
                       input logic [63:0] va, input logic [12:0] cx);
    acc_valid = 1'b1; acc_fetch = f; acc_store = s; ctx_sel = sel;
    user_mode = u; priv_state = p; trap_level = tl; hit = h;
    pte_priv = pp; pte_write = pw; vaddr = va; ctx_id = cx;
  endtask

  task automatic idle();
    acc_valid = 1'b0; dstat_rd = 1'b0; istat_rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_cmp++;
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [13:0] save_dstat, save_istat;
    logic [63:0] save_dfar, save_dtag, save_itag;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 dstat", 64'(dstat), 64'h0);
    chk("R11 istat", 64'(istat), 64'h0);
    chk("R11 dfar", dfar, 64'h0);
    chk("R11 tags", dtag | itag, 64'h0);
    chk("R11 kind", 64'(fault_kind), 64'h0);

    for (int i = 0; i < NV; i++) begin
      logic [21:0] v;
      logic [63:0] va;
      string tag;
      v  = VEC[i];
      va = {32'hC0DE_0000 + 32'(i), 32'h0000_5A5A};
      dstat_rd = 1'b1; istat_rd = 1'b1;
      @(negedge clk);
      idle();
      drive(v[21], v[20], v[19:18], v[17], v[16], v[15:13], v[12], v[11], v[10], va, 13'h0ABC);
      #1;
      tag = (v[9:8] == 2'd1) ? "R2" : (v[9:8] == 2'd2) ? "R3" : (v[9:8] == 2'd3) ? "R1" : "R4";
      chk(tag, 64'(fault_kind), 64'(v[9:8]));
      @(negedge clk);
      idle();
      if (v[9:8] == 2'd1 || v[9:8] == 2'd2) begin
        chk("R5 R8 status", 64'(v[21] ? istat : dstat), {56'h0, v[7:0]});
        if (!v[21]) chk("R7 far", dfar, va);
      end
    end

    save_istat = istat; save_itag = itag;
    // R6 back-to-back data faults
    dstat_rd = 1'b1; @(negedge clk); idle();
    drive(0, 1, 2'd0, 1, 0, 3'd0, 1, 0, 0, 64'hAAAA_0000_0000_2000, 13'h0011);
    @(negedge clk); idle();
    drive(0, 0, 2'd0, 1, 0, 3'd0, 1, 1, 1, 64'hBBBB_0000_0000_4321, 13'h0011);
    @(negedge clk); idle();
    chk("R6 overflow", 64'(dstat), 64'h83);
    chk("R7 far second", dfar, 64'hBBBB_0000_0000_4321);

    // R9 read strobe alone
    dstat_rd = 1'b1; @(negedge clk); idle();
    chk("R9 read clear", 64'(dstat), 64'h80);

    // R1 misses, nucleus and primary
    drive(0, 0, 2'd2, 1, 0, 3'd0, 0, 0, 0, 64'hCCCC_1234_5678_9FFF, 13'h1FFF);
    #1 chk("R1 miss kind", 64'(fault_kind), 64'h3);
    @(negedge clk); idle();
    chk("R1 status kept", 64'(dstat), 64'h80);
    chk("R1 far kept", dfar, 64'hBBBB_0000_0000_4321);
    chk("R8 nucleus tag", dtag, 64'hCCCC_1234_5678_8000);
    drive(0, 1, 2'd0, 0, 1, 3'd0, 0, 0, 0, 64'hDDDD_0000_0000_7FFF, 13'h0ABC);
    @(negedge clk); idle();
    chk("R1 primary tag", dtag, 64'hDDDD_0000_0000_6ABC);

    // R10 read and fault in one cycle
    drive(0, 1, 2'd0, 0, 1, 3'd0, 1, 0, 0, 64'hEEEE_0000_0000_0000, 13'h0123);
    @(negedge clk); idle();
    chk("R5 kernel store", 64'(dstat), 64'h0D);
    drive(0, 0, 2'd1, 1, 0, 3'd0, 1, 1, 1, 64'hFFFF_0000_0000_3456, 13'h0123);
    dstat_rd = 1'b1;
    @(negedge clk); idle();
    chk("R10 no overflow", 64'(dstat), 64'h91);
    chk("R7 tag on fault", dtag, 64'hFFFF_0000_0000_2123);
    chk("R12 istat kept", 64'(istat), 64'(save_istat));
    chk("R12 itag kept", itag, save_itag);

    // R12 / R8 fetch fault at trap level 1
    save_dstat = dstat; save_dfar = dfar; save_dtag = dtag;
    drive(1, 0, 2'd0, 1, 0, 3'd1, 1, 1, 1, 64'h1111_0000_0000_5555, 13'h0ABC);
    @(negedge clk); idle();
    chk("R8 fetch nucleus", 64'(istat), 64'hA1);
    chk("R8 fetch tag", itag, 64'h1111_0000_0000_4000);
    chk("R12 dstat kept", 64'(dstat), 64'(save_dstat));
    chk("R12 dfar kept", dfar, save_dfar);
    chk("R12 dtag kept", dtag, save_dtag);

    // R6 fetch side overflow
    drive(1, 0, 2'd0, 1, 0, 3'd0, 1, 1, 1, 64'h2222_0000_0000_0000, 13'h0001);
    @(negedge clk); idle();
    chk("R6 fetch overflow", 64'(istat), 64'h83);

    // R11 no valid access: nothing moves
    save_istat = istat; save_itag = itag;
    drive(0, 1, 2'd0, 1, 0, 3'd0, 0, 1, 0, 64'h3333_0000_0000_0000, 13'h0002);
    acc_valid = 1'b0;
    #1 chk("R11 idle kind", 64'(fault_kind), 64'h0);
    @(negedge clk); idle();
    chk("R11 idle dstat", 64'(dstat), 64'(save_dstat));
    chk("R11 idle dtag", dtag, save_dtag);
    chk("R11 idle itag", itag, save_itag);

    finish_run();
  end
endmodule